// File: doc/BRIEF.md
# Seconds-and-Fraction Real-Time Clock with Alarm

This block keeps wall time as a 47-bit count driven by a 32 kHz tick enable. The upper 32 bits hold whole seconds and the lower 15 bits hold the fraction of the current second. Software reaches the count, an alarm register, a run control, a status register and an interrupt mask through a small word-addressed register port.

The count stays frozen after reset. It starts only after two things have happened: software has loaded a time value at least once, and software has set the run bit. When a counting step lands the count exactly on the programmed alarm second, with the fraction at zero, the block sets a sticky alarm flag. It raises its interrupt line while that flag and the alarm mask bit are both set. Software clears the status flags by writing ones to them.

Top module: `rtc_core`

## Requirements
- R1: After reset the seconds, fraction, control and interrupt-mask registers read zero, the alarm seconds register reads 0xFFFFFFFF, and `irq_o` is low.
- R2: Offset 0x00 reads and loads the 32 seconds bits. Offset 0x04 reads and loads the 15 fraction bits in bits 14:0, and its bits 31:15 read zero.
- R3: The count advances by one on a clock where `tick_i` is high only if control bit 3 (run) is set and either time register has been written since reset. A fraction of 0x7FFF carries into the seconds, and the full 47-bit count wraps to zero.
- R4: When a time register is written in the same cycle as a qualifying tick, the written value is kept and that tick is lost.
- R5: Offset 0x08 reads and writes the alarm seconds. Offset 0x0C and every unmapped offset read zero, and writes to them change no register.
- R6: Status bit 4 (alarm) becomes set when a counting step moves the count onto {alarm seconds, fraction 0}. Loading the time registers with that value does not set it.
- R7: Writing a one to status bit 4 or bit 1 clears that bit, and writing a zero leaves it unchanged. If a clear and an alarm hit fall in the same cycle, the alarm bit ends set.
- R8: Status bit 1 (not-valid) is set at reset and stays set until software clears it. Status bit 0 reads zero.
- R9: Bit 4 of the mask register at offset 0x18 is readable and writable, and `irq_o` is high exactly while status bit 4 and mask bit 4 are both set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_i | input | 1 | 32 kHz count enable, one clock wide per tick |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | 5 | Byte offset of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i`, combinational |
| irq_o | output | 1 | Alarm interrupt request |

## Verification
Read data depends combinationally on `addr_i`, so it is due in the same cycle the offset is presented. A write, a counting step, a flag set and the interrupt line each show their effect in the cycle after the clock edge that captured them. The bench drives inputs just after a falling edge and compares `rdata_o` and `irq_o` shortly after that, against a model state that is advanced once per rising edge. Each result is therefore checked exactly one edge after the stimulus that caused it. Directed sequences put a write and a tick in the same cycle, and a status clear and an alarm hit in the same cycle, to pin down the priority rules.

// File: rtl/rtc_pkg.sv
// Package: shared offsets, bit positions and register-select type for the RTC.
// Assumes word-aligned byte offsets within a 32-byte window.
package rtc_pkg;
    localparam int OFS_TSEC  = 0;
    localparam int OFS_TFRAC = 4;
    localparam int OFS_ASEC  = 8;
    localparam int OFS_AFRAC = 12;
    localparam int OFS_CTRL  = 16;
    localparam int OFS_STAT  = 20;
    localparam int OFS_MASK  = 24;

    localparam int CTRL_RUN_BIT  = 3;
    localparam int ST_ALARM_BIT  = 4;
    localparam int ST_NVAL_BIT   = 1;
    localparam int MASK_ALM_BIT  = 4;

    typedef enum logic [2:0] {
        SEL_TSEC, SEL_TFRAC, SEL_ASEC, SEL_AFRAC,
        SEL_CTRL, SEL_STAT, SEL_MASK, SEL_NONE
    } reg_sel_e;
endpackage

// File: rtl/rtc_counter.sv
// Module: 47-bit seconds/fraction counter. It loads either half from the
// register port and steps on qualified ticks. Assumes FRAC_W <= SEC_W and
// that the two load strobes are never high together.
module rtc_counter #(
    parameter int SEC_W  = 32,
    parameter int FRAC_W = 15,
    localparam int TW    = SEC_W + FRAC_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             run_i,
    input  logic             ld_sec_i,
    input  logic             ld_frac_i,
    input  logic [SEC_W-1:0] wdata_i,
    output logic [TW-1:0]    time_o,
    output logic [TW-1:0]    next_o,
    output logic             adv_o
);
    logic [TW-1:0] time_q;
    logic          loaded_q;

    // step only when running, loaded and no load competes this cycle
    always_comb begin
        adv_o  = tick_i && run_i && loaded_q && !ld_sec_i && !ld_frac_i;
        next_o = time_q + TW'(1);
    end

    // count register: loads take priority, then the step
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            time_q   <= '0;
            loaded_q <= 1'b0;
        end else begin
            if (ld_sec_i)  time_q[TW-1:FRAC_W]   <= wdata_i;
            if (ld_frac_i) time_q[FRAC_W-1:0]    <= wdata_i[FRAC_W-1:0];
            if (ld_sec_i || ld_frac_i) loaded_q  <= 1'b1;
            if (adv_o)     time_q                <= next_o;
        end
    end

    assign time_o = time_q;

    // R3
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_sec_i && !ld_frac_i && !adv_o) |=> $stable(time_q));
    // R3
    step_by_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        adv_o |=> time_q == $past(time_q) + TW'(1));
endmodule

// File: rtl/rtc_alarm.sv
// Module: alarm seconds register and sticky alarm flag. The flag sets when a
// counting step lands on {alarm, zero fraction}. A set wins over a clear.
module rtc_alarm #(
    parameter int SEC_W  = 32,
    parameter int FRAC_W = 15,
    localparam int TW    = SEC_W + FRAC_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld_alm_i,
    input  logic [SEC_W-1:0] wdata_i,
    input  logic             adv_i,
    input  logic [TW-1:0]    next_i,
    input  logic             clr_i,
    output logic [SEC_W-1:0] alm_o,
    output logic             flag_o
);
    logic [SEC_W-1:0] alm_q;
    logic             flag_q;
    logic             hit;

    // match only on a counting step onto the alarm point
    always_comb hit = adv_i && (next_i == {alm_q, {FRAC_W{1'b0}}});

    // alarm seconds register, parked at all-ones after reset
    always_ff @(posedge clk) begin
        if (!rst_n)        alm_q <= '1;
        else if (ld_alm_i) alm_q <= wdata_i;
    end

    // sticky flag, set has priority over write-one-to-clear
    always_ff @(posedge clk) begin
        if (!rst_n)     flag_q <= 1'b0;
        else if (hit)   flag_q <= 1'b1;
        else if (clr_i) flag_q <= 1'b0;
    end

    assign alm_o  = alm_q;
    assign flag_o = flag_q;

    // R6
    flag_from_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q) |-> $past(adv_i));
    // R7
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !clr_i) |=> flag_q);
endmodule

// File: rtl/rtc_core.sv
// Module: RTC top. It decodes the register port, holds the run, not-valid and
// mask bits, and muxes read data. Assumes single-cycle writes and
// combinational reads on a word-aligned byte offset.
module rtc_core #(
    parameter int AW     = 5,
    parameter int SEC_W  = 32,
    parameter int FRAC_W = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             wr_i,
    input  logic [AW-1:0]    addr_i,
    input  logic [SEC_W-1:0] wdata_i,
    output logic [SEC_W-1:0] rdata_o,
    output logic             irq_o
);
    import rtc_pkg::*;
    localparam int TW = SEC_W + FRAC_W;

    reg_sel_e         sel;
    logic             run_q, nval_q, mask_q;
    logic [TW-1:0]    time_w, next_w;
    logic             adv_w, flag_w;
    logic [SEC_W-1:0] alm_w;
    logic             wr_stat;

    // offset decode
    always_comb begin
        unique case (addr_i)
            AW'(OFS_TSEC):  sel = SEL_TSEC;
            AW'(OFS_TFRAC): sel = SEL_TFRAC;
            AW'(OFS_ASEC):  sel = SEL_ASEC;
            AW'(OFS_AFRAC): sel = SEL_AFRAC;
            AW'(OFS_CTRL):  sel = SEL_CTRL;
            AW'(OFS_STAT):  sel = SEL_STAT;
            AW'(OFS_MASK):  sel = SEL_MASK;
            default:        sel = SEL_NONE;
        endcase
    end

    assign wr_stat = wr_i && (sel == SEL_STAT);

    rtc_counter #(.SEC_W(SEC_W), .FRAC_W(FRAC_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .run_i(run_q),
        .ld_sec_i(wr_i && sel == SEL_TSEC), .ld_frac_i(wr_i && sel == SEL_TFRAC),
        .wdata_i(wdata_i), .time_o(time_w), .next_o(next_w), .adv_o(adv_w)
    );

    rtc_alarm #(.SEC_W(SEC_W), .FRAC_W(FRAC_W)) u_alm (
        .clk(clk), .rst_n(rst_n), .ld_alm_i(wr_i && sel == SEL_ASEC),
        .wdata_i(wdata_i), .adv_i(adv_w), .next_i(next_w),
        .clr_i(wr_stat && wdata_i[ST_ALARM_BIT]),
        .alm_o(alm_w), .flag_o(flag_w)
    );

    // control, not-valid and mask bits
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q  <= 1'b0;
            nval_q <= 1'b1;
            mask_q <= 1'b0;
        end else if (wr_i) begin
            if (sel == SEL_CTRL) run_q  <= wdata_i[CTRL_RUN_BIT];
            if (sel == SEL_MASK) mask_q <= wdata_i[MASK_ALM_BIT];
            if (wr_stat && wdata_i[ST_NVAL_BIT]) nval_q <= 1'b0;
        end
    end

    // read mux
    always_comb begin
        rdata_o = '0;
        case (sel)
            SEL_TSEC:  rdata_o = time_w[TW-1:FRAC_W];
            SEL_TFRAC: rdata_o[FRAC_W-1:0] = time_w[FRAC_W-1:0];
            SEL_ASEC:  rdata_o = alm_w;
            SEL_CTRL:  rdata_o[CTRL_RUN_BIT] = run_q;
            SEL_STAT: begin
                rdata_o[ST_ALARM_BIT] = flag_w;
                rdata_o[ST_NVAL_BIT]  = nval_q;
            end
            SEL_MASK:  rdata_o[MASK_ALM_BIT] = mask_q;
            default:   rdata_o = '0;
        endcase
    end

    // interrupt request
    assign irq_o = flag_w && mask_q;

    // R8
    nval_clear_by_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(nval_q) |-> $past(wr_i && addr_i == AW'(OFS_STAT) && wdata_i[ST_NVAL_BIT]));
endmodule

// File: tb/rtc_core_bench.sv
// Bench: behavioural reference model advanced on every rising edge and
// compared against rdata_o and irq_o on every cycle.
module rtc_core_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_i = 1'b0;
    logic        wr_i = 1'b0;
    logic [4:0]  addr_i = '0;
    logic [31:0] wdata_i = '0;
    logic [31:0] rdata_o;
    logic        irq_o;

    int vectors = 0;
    int errors  = 0;
    bit done    = 1'b0;

    // model state
    logic [46:0] m_time;
    logic        m_loaded, m_run, m_caf, m_nval, m_mask;
    logic [31:0] m_alm;

    always #10 clk = ~clk;

    rtc_core u_rtc_core (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .wr_i(wr_i),
        .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_o(irq_o)
    );

    function automatic logic [31:0] exp_rd(input logic [4:0] a);
        case (a)
            5'h00: return m_time[46:15];
            5'h04: return {17'd0, m_time[14:0]};
            5'h08: return m_alm;
            5'h10: return {28'd0, m_run, 3'd0};
            5'h14: return {27'd0, m_caf, 2'd0, m_nval, 1'b0};
            5'h18: return {27'd0, m_mask, 4'd0};
            default: return 32'd0;
        endcase
    endfunction

    task automatic model_reset();
        m_time = '0; m_loaded = 0; m_run = 0; m_caf = 0;
        m_nval = 1; m_mask = 0; m_alm = 32'hFFFF_FFFF;
    endtask

    task automatic model_step(input logic w, input logic [4:0] a,
                              input logic [31:0] d, input logic t);
        logic        ld, adv, hit;
        logic [46:0] nxt;
        ld  = w && (a == 5'h00 || a == 5'h04);
        adv = t && m_run && m_loaded && !ld;
        nxt = m_time + 47'd1;
        hit = adv && (nxt == {m_alm, 15'd0});
        if (adv) m_time = nxt;
        if (w) begin
            case (a)
                5'h00: begin m_time[46:15] = d; m_loaded = 1; end
                5'h04: begin m_time[14:0] = d[14:0]; m_loaded = 1; end
                5'h08: m_alm = d;
                5'h10: m_run = d[3];
                5'h14: begin
                    if (d[4]) m_caf = 0;
                    if (d[1]) m_nval = 0;
                end
                5'h18: m_mask = d[4];
                default: ;
            endcase
        end
        if (hit) m_caf = 1;
    endtask

    // one clock: drive, compare, advance model at the edge
    task automatic cyc(input logic w, input logic [4:0] a, input logic [31:0] d,
                       input logic t, input string req);
        logic [31:0] e;
        @(negedge clk);
        wr_i = w; addr_i = a; wdata_i = d; tick_i = t;
        #2;
        e = exp_rd(a);
        vectors++;
        if (rdata_o !== e) begin
            errors++;
            $display("FAIL %s rdata @%h actual %h expected %h", req, a, rdata_o, e);
        end
        vectors++;
        if (irq_o !== (m_caf && m_mask)) begin
            errors++;
            $display("FAIL R9 irq (%s) actual %b expected %b", req, irq_o, m_caf && m_mask);
        end
        @(posedge clk);
        model_step(w, a, d, t);
    endtask

    task automatic rd(input logic [4:0] a, input string req);
        cyc(1'b0, a, 32'd0, 1'b0, req);
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d, input string req);
        cyc(1'b1, a, d, 1'b0, req);
    endtask

    task automatic ticks(input int n, input logic [4:0] a, input string req);
        for (int i = 0; i < n; i++) cyc(1'b0, a, 32'd0, 1'b1, req);
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual hung expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        logic [31:0] lfsr;
        logic [4:0]  amap [8];
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R1 R8: reset values of every register
        rd(5'h00, "R1"); rd(5'h04, "R1"); rd(5'h08, "R1"); rd(5'h10, "R1");
        rd(5'h14, "R8"); rd(5'h18, "R1");

        // R3: running but never loaded stays frozen
        wr(5'h10, 32'h8, "R3");
        ticks(5, 5'h04, "R3");
        rd(5'h00, "R3");

        // R2 R3: load fraction near the top, carry into seconds
        wr(5'h04, 32'hFFFF_7FFD, "R2");
        rd(5'h04, "R2");
        ticks(4, 5'h04, "R3");
        rd(5'h00, "R3");

        // R2: load seconds
        wr(5'h00, 32'h1234_5678, "R2");
        rd(5'h00, "R2");

        // R4: write beats a tick in the same cycle
        cyc(1'b1, 5'h04, 32'h0000_0100, 1'b1, "R4");
        rd(5'h04, "R4");
        cyc(1'b1, 5'h00, 32'h0000_0AAA, 1'b1, "R4");
        rd(5'h00, "R4"); rd(5'h04, "R4");

        // R3: clearing run stops the count
        wr(5'h10, 32'h0, "R3");
        ticks(3, 5'h04, "R3");
        wr(5'h10, 32'hFFFF_FFF7, "R3");
        ticks(2, 5'h04, "R3");
        wr(5'h10, 32'h8, "R3");

        // R5: alarm registers and unmapped offsets
        wr(5'h08, 32'h0000_0051, "R5");
        rd(5'h08, "R5");
        wr(5'h0C, 32'hDEAD_BEEF, "R5");
        rd(5'h0C, "R5");
        wr(5'h1C, 32'hFFFF_FFFF, "R5");
        rd(5'h1C, "R5"); rd(5'h08, "R5"); rd(5'h00, "R5");

        // R6 R9: count onto the alarm point
        wr(5'h18, 32'h10, "R9");
        rd(5'h18, "R9");
        wr(5'h00, 32'h0000_0050, "R6");
        wr(5'h04, 32'h0000_7FFD, "R6");
        ticks(2, 5'h14, "R6");
        rd(5'h14, "R6");
        ticks(1, 5'h14, "R6");
        rd(5'h14, "R6");
        ticks(3, 5'h14, "R6");

        // R7: writing zero leaves flags, writing one clears
        wr(5'h14, 32'h0, "R7");
        rd(5'h14, "R7");
        wr(5'h18, 32'h0, "R9");
        rd(5'h14, "R9");
        wr(5'h18, 32'h10, "R9");
        wr(5'h14, 32'h10, "R7");
        rd(5'h14, "R7");

        // R6: loading exactly the alarm point does not set the flag
        wr(5'h04, 32'h0, "R6");
        wr(5'h00, 32'h0000_0051, "R6");
        rd(5'h14, "R6");
        wr(5'h04, 32'h0, "R6");
        rd(5'h14, "R6");

        // R7: set wins over a clear in the same cycle
        wr(5'h08, 32'h0000_0061, "R7");
        wr(5'h00, 32'h0000_0060, "R7");
        wr(5'h04, 32'h0000_7FFF, "R7");
        cyc(1'b1, 5'h14, 32'h10, 1'b1, "R7");
        rd(5'h14, "R7"); rd(5'h00, "R7");

        // R8: clear not-valid
        wr(5'h14, 32'h2, "R8");
        rd(5'h14, "R8");
        wr(5'h14, 32'h12, "R8");
        rd(5'h14, "R8");

        // R3: full wrap of the 47-bit count
        wr(5'h00, 32'hFFFF_FFFF, "R3");
        wr(5'h04, 32'h7FFE, "R3");
        ticks(1, 5'h00, "R3");
        ticks(1, 5'h04, "R3");
        rd(5'h00, "R3"); rd(5'h04, "R3");

        // mixed pseudo-random traffic
        amap[0] = 5'h00; amap[1] = 5'h04; amap[2] = 5'h08; amap[3] = 5'h0C;
        amap[4] = 5'h10; amap[5] = 5'h14; amap[6] = 5'h18; amap[7] = 5'h1C;
        lfsr = 32'hACE1_1234;
        for (int i = 0; i < 3000; i++) begin
            logic [4:0]  a;
            logic [31:0] d;
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            a = amap[lfsr[2:0]];
            d = {lfsr[7:0], lfsr[31:8]};
            if (a == 5'h08 || a == 5'h00) d = {24'd0, d[7:0]};
            cyc(lfsr[5:3] == 3'd0, a, d, lfsr[9], "R3");
        end

        done = 1'b1;
        summary();
        $finish;
    end
endmodule